// File: doc/BRIEF.md
# Double-Word Arithmetic Shift Unit

This unit performs a signed arithmetic shift on a 32-bit value for a 16-bit processor core. The value arrives as two 16-bit halves. The core presents both halves and a 16-bit count operand, then pulses `start`. From the low six bits of the count, the unit decides among four cases: no shift, a left shift of 1 to 31 places, a fill with the sign bit, or a right shift of 1 to 31 places. The shifting itself is iterative, moving one bit per clock.

When the operation finishes, the unit raises `done` for exactly one cycle. In that cycle the two result halves and the four condition flags (negative, zero, overflow, carry) are valid. They stay unchanged until the next accepted `start`.

The controller is a four-state machine:

- `ST_IDLE` waits for `start`.
  - It goes to `ST_LEFT` for a left shift.
  - It goes to `ST_RIGHT` for a right shift.
  - It goes straight to `ST_DONE` for a zero count or a sign fill.
- `ST_LEFT` and `ST_RIGHT` move one bit per cycle. They go to `ST_DONE` on the edge that performs the last step.
- `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `dword_ash_unit`

## Requirements
- R1: The operand is `{op_hi, op_lo}`, with `op_hi` as bits 31..16. The result is returned in the same split: `res_hi` is bits 31..16 and `res_lo` is bits 15..0.
- R2: Only bits 5..0 of `shift_cnt` select the operation. Bits 15..6 have no effect on the result, the flags or the latency.
- R3: A count of 0 returns the operand unchanged, with C=0 and V=0.
- R4: A count n from 1 to 31 shifts left by n places with zero fill. C is the last bit moved out of bit 31.
- R5: During a left shift, V is set once bit 31 after any single step differs from the operand's original bit 31. V then remains set to the end, even if the final bit 31 matches the original.
- R6: A count of 32 returns 32 copies of the original bit 31. C equals the original bit 31, and V is the XOR of the original and final bit 31, which gives 0.
- R7: A count n from 33 to 63 is an arithmetic right shift by 64−n places with sign fill. C is the last bit moved out of bit 0, and V is the XOR of the original and final bit 31, which gives 0.
- R8: N equals result bit 31. Z is 1 exactly when all 32 result bits are zero.
- R9: `start` is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance through the `done` cycle. `done` is high for one cycle:
  - 1 cycle after the accepting cycle for counts 0 and 32;
  - n+1 cycles after it for a left shift by n;
  - 65−n cycles after it for counts 33..63.
  A `start` while busy has no effect.
- R10: After reset, `busy`=0, `done`=0, the result is 0, N=0, Z=1, V=0 and C=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; sampled while idle |
| op_hi | input | 16 | Upper half of the operand |
| op_lo | input | 16 | Lower half of the operand |
| shift_cnt | input | 16 | Count operand; bits 5..0 used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_hi | output | 16 | Upper half of the result |
| res_lo | output | 16 | Lower half of the result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
On every cycle, the checker enforces the handshake. It checks that `done` is a single-cycle pulse, that it follows an accepted request, and that it arrives exactly at the latency the latched count predicts. At each `done` it also checks the closed-form outcomes: the unchanged value for a zero count, the sign fill for a count of 32, and the sign-preserving result with V clear for right shifts.

Other behaviours are shown only by the directed scenarios:
- the exact shifted values and carries for left shifts;
- the sticky overflow, where the final sign matches but an intermediate step flipped it;
- the masking of the upper count bits;
- the rejection of a request while busy.

The scenarios compare all 64 counts on the boundary operands against an independent model.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [1:0] {
        SH_NONE,
        SH_LEFT,
        SH_FILL,
        SH_RIGHT
    } sh_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEFT,
        ST_RIGHT,
        ST_DONE
    } ctl_state_e;

endpackage

// File: rtl/dws_count_decode.sv
module dws_count_decode
    import dws_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] cnt,
    output sh_kind_e         kind,
    output logic [CNT_W-1:0] steps
);
    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(1 << (CNT_W - 1));

    always_comb begin
        steps = '0;
        if (cnt == '0) begin
            kind = SH_NONE;
        end else if (cnt < HALF_V) begin
            kind  = SH_LEFT;
            steps = cnt;
        end else if (cnt == HALF_V) begin
            kind = SH_FILL;
        end else begin
            kind  = SH_RIGHT;
            steps = CNT_W'(0) - cnt;
        end
    end
endmodule

// File: rtl/dws_datapath.sv
module dws_datapath
    import dws_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic             dir_left,
    input  logic [DW-1:0]    op_in,
    input  sh_kind_e         kind_in,
    input  logic [CNT_W-1:0] steps_in,
    output logic [DW-1:0]    value,
    output logic             orig_sign,
    output logic             carry,
    output logic             v_sticky,
    output sh_kind_e         kind_q,
    output logic             last_step
);
    logic [DW-1:0]    shl_next;
    logic [DW-1:0]    shr_next;
    logic [CNT_W-1:0] remain;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign shl_next[i] = 1'b0;
        end else begin : g_mid_l
            assign shl_next[i] = value[i-1];
        end
        if (i == DW - 1) begin : g_msb
            assign shr_next[i] = value[DW-1];
        end else begin : g_mid_r
            assign shr_next[i] = value[i+1];
        end
    end

    assign last_step = (remain == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value     <= '0;
            orig_sign <= 1'b0;
            carry     <= 1'b0;
            v_sticky  <= 1'b0;
            kind_q    <= SH_NONE;
            remain    <= '0;
        end else if (load) begin
            kind_q    <= kind_in;
            orig_sign <= op_in[DW-1];
            v_sticky  <= 1'b0;
            remain    <= steps_in;
            unique case (kind_in)
                SH_FILL: begin
                    value <= {DW{op_in[DW-1]}};
                    carry <= op_in[DW-1];
                end
                default: begin
                    value <= op_in;
                    carry <= 1'b0;
                end
            endcase
        end else if (shift_en) begin
            remain <= remain - CNT_W'(1);
            if (dir_left) begin
                value <= shl_next;
                carry <= value[DW-1];
                if (shl_next[DW-1] != orig_sign) begin
                    v_sticky <= 1'b1;
                end
            end else begin
                value <= shr_next;
                carry <= value[0];
            end
        end
    end
endmodule

// File: rtl/dws_flags.sv
module dws_flags
    import dws_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] value,
    input  logic          orig_sign,
    input  logic          carry,
    input  logic          v_sticky,
    input  sh_kind_e      kind_q,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    always_comb begin
        flag_n = value[DW-1];
        flag_z = (value == '0);
        flag_c = carry;
        if (kind_q == SH_LEFT) begin
            flag_v = v_sticky;
        end else begin
            flag_v = orig_sign ^ value[DW-1];
        end
    end
endmodule

// File: rtl/dws_ctrl.sv
module dws_ctrl
    import dws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  sh_kind_e   kind_in,
    input  logic       last_step,
    output logic       load,
    output logic       shift_en,
    output logic       dir_left,
    output logic       busy,
    output logic       done
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (kind_in)
                        SH_LEFT:  state_d = ST_LEFT;
                        SH_RIGHT: state_d = ST_RIGHT;
                        default:  state_d = ST_DONE;
                    endcase
                end
            end
            ST_LEFT, ST_RIGHT: begin
                if (last_step) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = (state_q == ST_IDLE) && start;
        shift_en = (state_q == ST_LEFT) || (state_q == ST_RIGHT);
        dir_left = (state_q == ST_LEFT);
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
    end
endmodule

// File: rtl/dword_ash_unit.sv
module dword_ash_unit
    import dws_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_hi,
    input  logic [WORD_W-1:0] op_lo,
    input  logic [WORD_W-1:0] shift_cnt,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    localparam int DW    = 2 * WORD_W;
    localparam int CNT_W = $clog2(DW) + 1;

    sh_kind_e         dec_kind;
    sh_kind_e         kind_q;
    logic [CNT_W-1:0] dec_steps;
    logic [DW-1:0]    value;
    logic             orig_sign;
    logic             carry;
    logic             v_sticky;
    logic             last_step;
    logic             load;
    logic             shift_en;
    logic             dir_left;

    dws_count_decode #(.CNT_W(CNT_W)) u_dec (
        .cnt   (shift_cnt[CNT_W-1:0]),
        .kind  (dec_kind),
        .steps (dec_steps)
    );

    dws_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind_in   (dec_kind),
        .last_step (last_step),
        .load      (load),
        .shift_en  (shift_en),
        .dir_left  (dir_left),
        .busy      (busy),
        .done      (done)
    );

    dws_datapath #(.DW(DW), .CNT_W(CNT_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift_en  (shift_en),
        .dir_left  (dir_left),
        .op_in     ({op_hi, op_lo}),
        .kind_in   (dec_kind),
        .steps_in  (dec_steps),
        .value     (value),
        .orig_sign (orig_sign),
        .carry     (carry),
        .v_sticky  (v_sticky),
        .kind_q    (kind_q),
        .last_step (last_step)
    );

    dws_flags #(.DW(DW)) u_flags (
        .value     (value),
        .orig_sign (orig_sign),
        .carry     (carry),
        .v_sticky  (v_sticky),
        .kind_q    (kind_q),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_v    (flag_v),
        .flag_c    (flag_c)
    );

    assign res_hi = value[DW-1:WORD_W];
    assign res_lo = value[WORD_W-1:0];
endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] op_hi,
    input logic [WORD_W-1:0] op_lo,
    input logic [WORD_W-1:0] shift_cnt,
    input logic [WORD_W-1:0] res_hi,
    input logic [WORD_W-1:0] res_lo,
    input logic              flag_v,
    input logic              flag_c
);
    localparam int DW    = 2 * WORD_W;
    localparam int CNT_W = $clog2(DW) + 1;
    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(1 << (CNT_W - 1));

    logic             pend;
    logic [CNT_W:0]   elapsed;
    logic [CNT_W:0]   exp_lat;
    logic [DW-1:0]    op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    res;
    logic [CNT_W-1:0] cnt_low;

    assign res     = {res_hi, res_lo};
    assign cnt_low = shift_cnt[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            elapsed <= '0;
            exp_lat <= '0;
            op_q    <= '0;
            cnt_q   <= '0;
        end else if (start && !busy) begin
            pend    <= 1'b1;
            elapsed <= (CNT_W+1)'(1);
            op_q    <= {op_hi, op_lo};
            cnt_q   <= cnt_low;
            if (cnt_low == '0 || cnt_low == HALF_V) begin
                exp_lat <= (CNT_W+1)'(1);
            end else if (cnt_low < HALF_V) begin
                exp_lat <= (CNT_W+1)'(cnt_low) + (CNT_W+1)'(1);
            end else begin
                exp_lat <= (CNT_W+1)'(2 * (1 << (CNT_W - 1)) + 1) - (CNT_W+1)'(cnt_low);
            end
        end else if (pend) begin
            if (done) begin
                pend <= 1'b0;
            end else begin
                elapsed <= elapsed + (CNT_W+1)'(1);
            end
        end
    end

    p_done_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend && elapsed == exp_lat));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cnt_q == '0) |-> (res == op_q && !flag_c && !flag_v));

    p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cnt_q == HALF_V) |->
            (res == {DW{op_q[DW-1]}} && flag_c == op_q[DW-1] && !flag_v));

    p_right_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cnt_q > HALF_V) |-> (!flag_v && res[DW-1] == op_q[DW-1]));
endmodule

bind dword_ash_unit dws_checker #(.WORD_W(WORD_W)) u_dws_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .op_hi     (op_hi),
    .op_lo     (op_lo),
    .shift_cnt (shift_cnt),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .flag_v    (flag_v),
    .flag_c    (flag_c)
);

// File: tb/dword_ash_unit_tb_top.sv
module dword_ash_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_hi = '0;
    logic [15:0] op_lo = '0;
    logic [15:0] shift_cnt = '0;
    logic        busy, done, flag_n, flag_z, flag_v, flag_c;
    logic [15:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dword_ash_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_hi(op_hi), .op_lo(op_lo), .shift_cnt(shift_cnt),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent model: result in [35:4], flags {N,Z,V,C} in [3:0]
    function automatic logic [35:0] ref_model(input logic [31:0] x, input logic [15:0] craw);
        logic [5:0]  n = craw[5:0];
        logic [31:0] r = x;
        logic        s = x[31];
        logic        v = 1'b0;
        logic        c = 1'b0;
        if (n == 0) begin
        end else if (n < 32) begin
            for (int i = 0; i < int'(n); i++) begin
                c = r[31];
                r = r << 1;
                if (r[31] != s) v = 1'b1;
            end
        end else if (n == 32) begin
            r = {32{s}};
            c = s;
            v = s ^ r[31];
        end else begin
            for (int i = 0; i < 64 - int'(n); i++) begin
                c = r[0];
                r = {r[31], r[31:1]};
            end
            v = s ^ r[31];
        end
        return {r, r[31], (r == 32'd0), v, c};
    endfunction

    function automatic int ref_lat(input logic [15:0] craw);
        int n = int'(craw[5:0]);
        if (n == 0 || n == 32) return 1;
        if (n < 32) return n + 1;
        return 65 - n;
    endfunction

    task automatic run_one(input logic [31:0] op, input logic [15:0] cnt,
                           output logic [31:0] res, output logic [3:0] nzvc,
                           output int lat);
        @(negedge clk);
        op_hi = op[31:16];
        op_lo = op[15:0];
        shift_cnt = cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res  = {res_hi, res_lo};
        nzvc = {flag_n, flag_z, flag_v, flag_c};
    endtask

    task automatic t_reset();
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 result", {res_hi, res_lo}, 0);
        chk("R10 flags NZVC", {flag_n, flag_z, flag_v, flag_c}, 4'b0100);
    endtask

    task automatic t_halves();
        logic [31:0] r; logic [3:0] f; int l;
        run_one(32'h1234_5678, 16'd0, r, f, l);
        chk("R1 res_hi", res_hi, 16'h1234);
        chk("R1 res_lo", res_lo, 16'h5678);
        run_one(32'h0000_8001, 16'd4, r, f, l);
        chk("R1 carry across halves", r, 32'h0008_0010);
    endtask

    task automatic t_sweep(input logic [31:0] op);
        for (int k = 0; k < 64; k++) begin
            logic [31:0] r; logic [3:0] f; int l;
            logic [35:0] e;
            string tag;
            e = ref_model(op, 16'(k));
            run_one(op, 16'(k), r, f, l);
            if (k == 0) tag = "R3";
            else if (k < 32) tag = "R4";
            else if (k == 32) tag = "R6";
            else tag = "R7";
            chk($sformatf("%s result op=%h cnt=%0d", tag, op, k), r, e[35:4]);
            chk($sformatf("R5/R8 %s flags op=%h cnt=%0d", tag, op, k), f, e[3:0]);
            chk($sformatf("R9 latency cnt=%0d", k), l, ref_lat(16'(k)));
        end
    endtask

    task automatic t_sticky();
        logic [31:0] r; logic [3:0] f; int l;
        // bit 31 flips at step 1, returns to original sign at step 2
        run_one(32'h4000_0000, 16'd2, r, f, l);
        chk("R5 sticky result", r, 32'h0000_0000);
        chk("R5 sticky NZVC", f, 4'b0111);
        run_one(32'h8000_0000, 16'd32, r, f, l);
        chk("R6 negative fill", r, 32'hFFFF_FFFF);
        chk("R6 negative fill NZVC", f, 4'b1001);
    endtask

    task automatic t_upper_ignored();
        logic [31:0] r1, r2; logic [3:0] f1, f2; int l1, l2;
        run_one(32'h8765_4321, 16'h0005, r1, f1, l1);
        run_one(32'h8765_4321, 16'hFFC5, r2, f2, l2);
        chk("R2 result same", r2, r1);
        chk("R2 flags same", f2, f1);
        chk("R2 latency same", l2, l1);
        run_one(32'h0000_00F0, 16'hFFC0, r2, f2, l2);
        chk("R2 zero count with upper bits", r2, 32'h0000_00F0);
    endtask

    task automatic t_busy_ignore();
        int lat;
        logic [31:0] r;
        bit extra_done;
        @(negedge clk);
        op_hi = 16'h0001; op_lo = 16'h0003; shift_cnt = 16'd20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        @(negedge clk); lat++;
        chk("R9 busy during shift", busy, 1);
        op_hi = 16'hAAAA; op_lo = 16'h5555; shift_cnt = 16'd0; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        r = {res_hi, res_lo};
        chk("R9 first request latency", lat, 21);
        chk("R9 start while busy ignored", r, 32'h0030_0000);
        extra_done = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done) extra_done = 1'b1;
        end
        chk("R9 no second done", extra_done, 0);
        chk("R9 idle after done", busy, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halves();
        t_sticky();
        t_upper_ignored();
        t_busy_ignore();
        t_sweep(32'h8000_0000);
        t_sweep(32'h7FFF_FFFF);
        t_sweep(32'h0000_0000);
        t_sweep(32'hFFFF_FFFF);
        t_sweep(32'h1234_5678);
        t_sweep(32'hC000_0001);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule